// File: doc/BRIEF.md
# Leaf Entry Permission Checker with Reference/Change Update

This block sits after a page-table walker. It receives the leaf entry that the walk found, the memory address that entry was read from, the kind of access (load, store or instruction fetch), whether the access comes from user or supervisor mode, whether the check is partition-scoped or process-scoped, and a three-bit permission mask that narrows supervisor access. From these inputs it works out the read/write/execute rights that the access is granted. It then decides whether the access faults and, if it does, which cause bits to report.

When the access is legal, the block marks the entry as referenced. A store also marks the entry as changed. If this alters the entry, the new value goes back to its memory address over a simple write port with an acknowledge. A load or fetch never receives write permission. This forces the first store to a clean page back through the block, so that the change bit is set before any write is allowed.

A request is accepted with a one-cycle `start` while the block is idle. The controller moves through four states: IDLE, EVAL, WRITE and DONE.
- **IDLE:** `start` captures the inputs and moves to EVAL.
- **EVAL:** the controller registers the verdict. It goes to WRITE when the entry must be stored back, and to DONE otherwise.
- **WRITE:** `wr_en` is held until `wr_ack`, then the controller moves to DONE.
- **DONE:** `done` is raised for one cycle, with `fault`, `cause` and `grant` valid, and the controller returns to IDLE.

Top module: `leaf_perm_check`

## Requirements
- R1: A fetch (access code 2'b10) to an entry whose attribute field, bits 5:4, equals 2'b10 (non-idempotent I/O) faults with cause 3'b001. Loads to such entries and fetches to entries with other attribute values are not affected by this rule.
- R2: In a process-scoped check (`part_scope`=0), a user-mode access to an entry with the privileged bit (bit 3) set is given no permissions. It therefore faults.
- R3: When the access is from user mode, the entry is privileged, or the check is partition-scoped, the available rights equal entry bits 2:0. In these bits, bit 2 is read, bit 1 is write and bit 0 is execute. The mask is not applied.
- R4: A supervisor-mode, process-scoped access to a non-privileged entry gets entry bits 2:0 ANDed with `mask_perm`.
- R5: A fault occurs when the right the access needs is missing: read for a load (2'b00), write for a store (2'b01), execute for a fetch (2'b10). A fetch fault reports cause 3'b001, and a data fault sets cause bit 1. On any fault `grant` reads 3'b000.
- R6: A data fault caused by a store also sets cause bit 2, giving cause 3'b110.
- R7: A legal access sets the reference bit (bit 8) of the entry. A legal store also sets the change bit (bit 7). All other entry bits are kept.
- R8: For a legal load or fetch, `grant` has the write bit cleared. A legal store keeps the write bit.
- R9: The entry is written to its captured address only when the updated value differs from the original. While `wr_ack` is low, `wr_en`, `wr_addr` and `wr_data` hold steady.
- R10: `done` is a single-cycle pulse. It comes one cycle after the acknowledged write, or two cycles after `start` when there is no write. A faulting access never writes.
- R11: After reset the block is idle, with `done` and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| ent_in | input | PTE_W | Leaf entry from the walk |
| ent_addr | input | ADDR_W | Memory address of the leaf entry |
| acc_type | input | 2 | 00 load, 01 store, 10 fetch |
| user_mode | input | 1 | 1 = user-mode access |
| part_scope | input | 1 | 1 = partition-scoped check |
| mask_perm | input | 3 | Read/write/execute mask for supervisor access |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Access is refused |
| cause | output | 3 | bit0 no-exec/guarded, bit1 protection, bit2 store |
| grant | output | 3 | Granted read/write/execute rights |
| wr_en | output | 1 | Entry write-back request |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Updated entry |
| wr_ack | input | 1 | Write-back accepted |

## Verification
The case to watch is a store to a writable page whose change bit is clear. On that one access the block must set the change bit, write the entry back and grant write. The bench drives stores to the same page with the change bit clear and then set. It checks that write permission appears in both results, while the write-back happens only in the first. A held-off `wr_ack` shows that `done` never comes before the entry update has been accepted.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVAL,
        S_WRITE,
        S_DONE
    } st_e;

    // entry bit positions
    localparam int REF_BIT  = 8;
    localparam int CHG_BIT  = 7;
    localparam int ATTR_HI  = 5;
    localparam int ATTR_LO  = 4;
    localparam int PRIV_BIT = 3;
    localparam logic [1:0] ATTR_NIIO = 2'b10;

    // rights vector positions
    localparam int P_RD = 2;
    localparam int P_WR = 1;
    localparam int P_EX = 0;

    // cause vector positions
    localparam int C_NOEXEC = 0;
    localparam int C_PROT   = 1;
    localparam int C_STORE  = 2;

endpackage

// File: rtl/pchk_perm_eval.sv
module pchk_perm_eval
    import pchk_pkg::*;
(
    input  logic [5:0] ent_lo,
    input  logic [1:0] acc,
    input  logic       user_mode,
    input  logic       part_scope,
    input  logic [2:0] mask_perm,
    output logic       fault,
    output logic [2:0] cause,
    output logic [2:0] perm
);

    logic       is_store;
    logic       is_fetch;
    logic       is_priv;
    logic       is_niio;
    logic [2:0] auth;
    logic [2:0] avail;
    logic [2:0] need;

    always_comb begin
        is_store = (acc == ACC_STORE);
        is_fetch = (acc == ACC_FETCH);
        auth     = ent_lo[2:0];
        is_priv  = ent_lo[PRIV_BIT];
        is_niio  = (ent_lo[ATTR_HI:ATTR_LO] == ATTR_NIIO);

        need = 3'b000;
        if (is_fetch)      need[P_EX] = 1'b1;
        else if (is_store) need[P_WR] = 1'b1;
        else               need[P_RD] = 1'b1;

        // rights available before the access type is considered
        if (!part_scope && is_priv && user_mode)
            avail = 3'b000;
        else if (user_mode || is_priv || part_scope)
            avail = auth;
        else
            avail = auth & mask_perm;

        fault = 1'b0;
        cause = 3'b000;
        perm  = 3'b000;
        if (is_niio && is_fetch) begin
            fault           = 1'b1;
            cause[C_NOEXEC] = 1'b1;
        end else if ((need & ~avail) != 3'b000) begin
            fault = 1'b1;
            if (is_fetch) begin
                cause[C_NOEXEC] = 1'b1;
            end else begin
                cause[C_PROT]  = 1'b1;
                cause[C_STORE] = is_store;
            end
        end else begin
            perm = avail;
        end
    end

endmodule

// File: rtl/pchk_rc_merge.sv
module pchk_rc_merge
    import pchk_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] ent,
    input  logic [1:0]       acc,
    input  logic             fault,
    input  logic [2:0]       perm,
    output logic [PTE_W-1:0] upd,
    output logic             need_wr,
    output logic [2:0]       grant
);

    always_comb begin
        upd   = ent;
        grant = perm;
        if (!fault) begin
            upd[REF_BIT] = 1'b1;
            if (acc == ACC_STORE)
                upd[CHG_BIT] = 1'b1;
            else
                grant[P_WR] = 1'b0;   // next store must come back to set change
        end
        need_wr = !fault && (upd != ent);
    end

endmodule

// File: rtl/leaf_perm_check.sv
module leaf_perm_check
    import pchk_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTE_W-1:0]  ent_in,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [1:0]        acc_type,
    input  logic              user_mode,
    input  logic              part_scope,
    input  logic [2:0]        mask_perm,
    output logic              done,
    output logic              fault,
    output logic [2:0]        cause,
    output logic [2:0]        grant,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTE_W-1:0]  wr_data,
    input  logic              wr_ack
);

    localparam int LO_W = ATTR_HI + 1;

    st_e               st, st_nxt;
    logic [PTE_W-1:0]  ent_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        acc_q;
    logic              user_q;
    logic              part_q;
    logic [2:0]        mask_q;

    logic              res_fault;
    logic [2:0]        res_cause;
    logic [2:0]        res_grant;
    logic [PTE_W-1:0]  upd_q;

    logic              ev_fault;
    logic [2:0]        ev_cause;
    logic [2:0]        ev_perm;
    logic [PTE_W-1:0]  mg_upd;
    logic              mg_need_wr;
    logic [2:0]        mg_grant;

    pchk_perm_eval u_eval (
        .ent_lo     (ent_q[LO_W-1:0]),
        .acc        (acc_q),
        .user_mode  (user_q),
        .part_scope (part_q),
        .mask_perm  (mask_q),
        .fault      (ev_fault),
        .cause      (ev_cause),
        .perm       (ev_perm)
    );

    pchk_rc_merge #(.PTE_W(PTE_W)) u_merge (
        .ent     (ent_q),
        .acc     (acc_q),
        .fault   (ev_fault),
        .perm    (ev_perm),
        .upd     (mg_upd),
        .need_wr (mg_need_wr),
        .grant   (mg_grant)
    );

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            ent_q     <= '0;
            addr_q    <= '0;
            acc_q     <= '0;
            user_q    <= 1'b0;
            part_q    <= 1'b0;
            mask_q    <= '0;
            res_fault <= 1'b0;
            res_cause <= '0;
            res_grant <= '0;
            upd_q     <= '0;
        end else begin
            st <= st_nxt;
            if (st == S_IDLE && start) begin
                ent_q  <= ent_in;
                addr_q <= ent_addr;
                acc_q  <= acc_type;
                user_q <= user_mode;
                part_q <= part_scope;
                mask_q <= mask_perm;
            end
            if (st == S_EVAL) begin
                res_fault <= ev_fault;
                res_cause <= ev_cause;
                res_grant <= mg_grant;
                upd_q     <= mg_upd;
            end
        end
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:  if (start) st_nxt = S_EVAL;
            S_EVAL:  st_nxt = mg_need_wr ? S_WRITE : S_DONE;
            S_WRITE: if (wr_ack) st_nxt = S_DONE;
            S_DONE:  st_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done    = (st == S_DONE);
        wr_en   = (st == S_WRITE);
        wr_addr = addr_q;
        wr_data = upd_q;
        fault   = res_fault;
        cause   = res_cause;
        grant   = res_grant;
    end

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ack) |=> (wr_en && $stable(wr_data) && $stable(wr_addr)));

    p_wr_differs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data != ent_q));

    p_wr_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[REF_BIT]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ro_nonstore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && acc_q != ACC_STORE) |-> !grant[P_WR]);

    p_fault_noperm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (grant == 3'b000));

endmodule

// File: tb/test_leaf_perm_check.sv
`timescale 1ns/1ps
module test_leaf_perm_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ent_in = '0;
    logic [47:0] ent_addr = '0;
    logic [1:0]  acc_type = '0;
    logic        user_mode = 1'b0;
    logic        part_scope = 1'b0;
    logic [2:0]  mask_perm = '0;
    logic        done, fault, wr_en;
    logic [2:0]  cause, grant;
    logic [47:0] wr_addr;
    logic [63:0] wr_data;
    logic        wr_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    leaf_perm_check i_leaf_perm_check (
        .clk(clk), .rst_n(rst_n), .start(start), .ent_in(ent_in),
        .ent_addr(ent_addr), .acc_type(acc_type), .user_mode(user_mode),
        .part_scope(part_scope), .mask_perm(mask_perm), .done(done),
        .fault(fault), .cause(cause), .grant(grant), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
    );

    typedef struct packed {
        logic [15:0] pte;
        logic [1:0]  acc;
        logic        usr;
        logic        prt;
        logic [2:0]  msk;
        logic        efault;
        logic [2:0]  ecause;
        logic [2:0]  eperm;
        logic        ewr;
        logic [15:0] ewdata;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'h0006, 2'b00, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b100, 1'b1, 16'h0106}, // R7 R8
        '{16'h0006, 2'b01, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b110, 1'b1, 16'h0186}, // R7
        '{16'h0186, 2'b01, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b110, 1'b0, 16'h0000}, // R9
        '{16'h0106, 2'b00, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b100, 1'b0, 16'h0000}, // R8 R9
        '{16'h0021, 2'b10, 1'b0, 1'b0, 3'b111, 1'b1, 3'b001, 3'b000, 1'b0, 16'h0000}, // R1
        '{16'h000E, 2'b00, 1'b1, 1'b0, 3'b111, 1'b1, 3'b010, 3'b000, 1'b0, 16'h0000}, // R2
        '{16'h000E, 2'b01, 1'b1, 1'b0, 3'b111, 1'b1, 3'b110, 3'b000, 1'b0, 16'h0000}, // R2 R6
        '{16'h000E, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 3'b000, 3'b100, 1'b1, 16'h010E}, // R3
        '{16'h0007, 2'b01, 1'b0, 1'b0, 3'b101, 1'b1, 3'b110, 3'b000, 1'b0, 16'h0000}, // R4 R6
        '{16'h0007, 2'b00, 1'b0, 1'b0, 3'b101, 1'b0, 3'b000, 3'b101, 1'b1, 16'h0107}, // R4
        '{16'h0006, 2'b10, 1'b0, 1'b0, 3'b111, 1'b1, 3'b001, 3'b000, 1'b0, 16'h0000}, // R5
        '{16'h0005, 2'b10, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 3'b101, 1'b1, 16'h0105}, // R3
        '{16'h0103, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 3'b011, 1'b1, 16'h0183}, // R3
        '{16'h0109, 2'b10, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000, 3'b001, 1'b0, 16'h0000}, // R3
        '{16'h0024, 2'b00, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b100, 1'b1, 16'h0124}, // R1
        '{16'h0011, 2'b10, 1'b0, 1'b0, 3'b111, 1'b0, 3'b000, 3'b001, 1'b1, 16'h0111}  // R1
    };

    logic        o_fault, o_after;
    logic [2:0]  o_cause, o_grant;
    logic [63:0] o_wdata;
    logic [47:0] o_waddr;
    int          o_wr_cyc;
    logic        o_hold_bad, o_got;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] pte, input logic [47:0] addr,
                          input logic [1:0] acc, input logic usr, input logic prt,
                          input logic [2:0] msk, input int ack_dly);
        int cyc = 0;
        logic [63:0] first_wd = '0;
        @(negedge clk);
        ent_in = pte; ent_addr = addr; acc_type = acc;
        user_mode = usr; part_scope = prt; mask_perm = msk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        o_got = 1'b0; o_wr_cyc = 0; o_hold_bad = 1'b0; o_wdata = '0; o_waddr = '0;
        while (!o_got && cyc < 100) begin
            if (done) begin
                o_got = 1'b1;
                o_fault = fault; o_cause = cause; o_grant = grant;
            end else begin
                wr_ack = 1'b0;
                if (wr_en) begin
                    if (o_wr_cyc == 0) begin
                        first_wd = wr_data; o_wdata = wr_data; o_waddr = wr_addr;
                    end else if (wr_data != first_wd) begin
                        o_hold_bad = 1'b1;
                    end
                    if (o_wr_cyc >= ack_dly) wr_ack = 1'b1;
                    o_wr_cyc++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        wr_ack = 1'b0;
        @(negedge clk);
        o_after = done;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && wr_en == 1'b0, "R11 in reset", {done, wr_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && wr_en == 1'b0, "R11 after reset", {done, wr_en}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op({48'h0, VECS[i].pte}, 48'h1000 + 48'(i * 8), VECS[i].acc,
                   VECS[i].usr, VECS[i].prt, VECS[i].msk, 0);
            chk(o_got, $sformatf("R10 vec%0d done seen", i), o_got, 1);
            chk(o_fault == VECS[i].efault, $sformatf("R5 vec%0d fault", i),
                o_fault, VECS[i].efault);
            chk(o_cause == VECS[i].ecause, $sformatf("R1/R6 vec%0d cause", i),
                o_cause, VECS[i].ecause);
            chk(o_grant == VECS[i].eperm, $sformatf("R3/R4/R8 vec%0d grant", i),
                o_grant, VECS[i].eperm);
            chk((o_wr_cyc != 0) == VECS[i].ewr, $sformatf("R9 vec%0d write", i),
                o_wr_cyc, VECS[i].ewr);
            if (VECS[i].ewr) begin
                chk(o_wdata == {48'h0, VECS[i].ewdata}, $sformatf("R7 vec%0d data", i),
                    o_wdata, {48'h0, VECS[i].ewdata});
                chk(o_waddr == 48'h1000 + 48'(i * 8), $sformatf("R9 vec%0d addr", i),
                    o_waddr, 48'h1000 + 48'(i * 8));
            end
            chk(o_after == 1'b0, $sformatf("R10 vec%0d pulse", i), o_after, 0);
        end

        // store to clean page with held-off ack, upper bits kept
        run_op(64'hABCD_0000_0000_0006, 48'h7777_0000_0040, 2'b01, 1'b0, 1'b0, 3'b111, 3);
        chk(o_wr_cyc == 4, "R10 done waits for ack", o_wr_cyc, 4);
        chk(!o_hold_bad, "R9 data held until ack", o_hold_bad, 0);
        chk(o_wdata == 64'hABCD_0000_0000_0186, "R7 upper bits kept", o_wdata,
            64'hABCD_0000_0000_0186);
        chk(o_waddr == 48'h7777_0000_0040, "R9 address", o_waddr, 48'h7777_0000_0040);
        chk(o_grant == 3'b110 && !o_fault, "R8 store keeps write", o_grant, 3'b110);
        chk(o_after == 1'b0, "R10 pulse after ack", o_after, 0);

        // same page now dirty: write granted, no write-back
        run_op(64'hABCD_0000_0000_0186, 48'h7777_0000_0040, 2'b01, 1'b0, 1'b0, 3'b111, 0);
        chk(o_wr_cyc == 0, "R9 no write when unchanged", o_wr_cyc, 0);
        chk(o_grant == 3'b110, "R8 dirty store grant", o_grant, 3'b110);

        // store fault with nothing writable must not write
        run_op(64'h0000_0000_0000_0004, 48'h10, 2'b01, 1'b1, 1'b1, 3'b111, 0);
        chk(o_fault && o_cause == 3'b110, "R6 partition store fault", o_cause, 3'b110);
        chk(o_wr_cyc == 0, "R10 fault never writes", o_wr_cyc, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule